// File: doc/BRIEF.md
# Refresh-Loss Segment Blanking Watchdog

This block guards a multiplexed display against being left lit with one frozen pattern when the logic that refreshes it stops. It watches two event strobes from the refresh source: one pulses when a new display field is started, and one pulses when segment data is written. Each event restarts a retriggerable down-counter. If the counter runs out with no event, the block drives an active-low clear that empties the segment latches. The digit-select latch is not on this clear path and keeps its contents. The clear is released by the next event.

An operator can also blank the display by command. A blank command latches a manual hold that keeps the clear active whatever the refresh activity is. A restore command drops the hold. Restore wins when both commands arrive on the same clock. The `man_blank` status output shows whether the manual hold is set.

The control is a three-state machine. ST_RUN means the segments are live. ST_STALE means the timeout has run out. ST_HELD means a manual blank is in force. Its transitions are:
- T_EXPIRE goes from ST_RUN to ST_STALE when the counter is at zero and no event comes.
- T_RESUME goes from ST_STALE to ST_RUN on any event.
- T_BLANK goes from ST_RUN or ST_STALE to ST_HELD on an effective blank command.
- T_RELEASE_LIVE goes from ST_HELD to ST_RUN on restore, when an event comes in that cycle or the counter has not yet reached zero.
- T_RELEASE_STALE goes from ST_HELD to ST_STALE on restore when the counter is at zero and no event comes.

Top module: `disp_blank_wd`

## Requirements
- R1: Out of reset, `seg_clr_n` is 1 and `man_blank` is 0.
- R2: If no event (`field_stb` or `seg_stb` high at a clock edge) is seen for TIMEOUT_CYC+1 consecutive edges, `seg_clr_n` goes to 0 after the (TIMEOUT_CYC+1)-th edge. It stays 1 after the TIMEOUT_CYC-th edge. The count starts from the last event edge or from the release of reset.
- R3: `seg_clr_n` is active low, and a value of 0 means the segment latches are cleared.
- R4: Either strobe alone restarts the timeout. If events come at most TIMEOUT_CYC+1 edges apart and no manual blank is set, `seg_clr_n` stays 1.
- R5: After a timeout clear, with no manual blank set, the first event edge returns `seg_clr_n` to 1 right after that edge.
- R6: A blank command (`blank_cmd`=1, `restore_cmd`=0) at an edge sets `man_blank` to 1 and `seg_clr_n` to 0 after that edge. Both hold no matter what events come, until a restore command is seen.
- R7: A restore command at an edge clears `man_blank` after that edge. `seg_clr_n` then returns to 1 if an event came in that cycle or fewer than TIMEOUT_CYC+1 idle edges have passed.
- R8: When `blank_cmd` and `restore_cmd` are both 1 at an edge, restore takes priority: `man_blank` is 0 after that edge.
- R9: A restore issued after TIMEOUT_CYC+1 or more idle edges, with no event in that cycle, leaves `seg_clr_n` at 0 with `man_blank` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| field_stb | input | 1 | Pulse from the refresh source when a new display field starts |
| seg_stb | input | 1 | Pulse from the refresh source when segment data is written |
| blank_cmd | input | 1 | Manual blank request |
| restore_cmd | input | 1 | Manual restore request |
| seg_clr_n | output | 1 | Active-low clear for the segment latches |
| man_blank | output | 1 | Status: manual blank hold is set |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a refresh event and the counter reaching zero. The second pair is a blank command and a restore command. The bench lines up an event exactly on the last allowed idle edge and expects the clear to stay off. It drives both commands in one cycle, once while running and once while held, and expects restore to win in both cases. It also issues a restore while the timeout has already run out, to check that the watchdog clear outlasts the release of the manual hold.

// File: rtl/disp_blank_wd_pkg.sv
package disp_blank_wd_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_STALE = 2'd1,
        ST_HELD  = 2'd2
    } wd_state_e;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_BLANK   = 2'd1,
        CMD_RESTORE = 2'd2
    } man_cmd_e;

endpackage

// File: rtl/blk_act_timer.sv
module blk_act_timer #(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(TIMEOUT_CYC);

    logic [CW-1:0] remain_q;

    // Any event reloads; otherwise count down to zero and hold there.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= LOAD_VAL;
        end else if (reload) begin
            remain_q <= LOAD_VAL;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign expired = (remain_q == '0);
endmodule

// File: rtl/blk_cmd_arb.sv
module blk_cmd_arb
    import disp_blank_wd_pkg::*;
(
    input  logic     blank_cmd,
    input  logic     restore_cmd,
    output man_cmd_e cmd
);
    // Restore outranks blank when both are present.
    always_comb begin
        if (restore_cmd) begin
            cmd = CMD_RESTORE;
        end else if (blank_cmd) begin
            cmd = CMD_BLANK;
        end else begin
            cmd = CMD_NONE;
        end
    end
endmodule

// File: rtl/blk_wd_fsm.sv
module blk_wd_fsm
    import disp_blank_wd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     evt,
    input  logic     expired,
    input  man_cmd_e cmd,
    output wd_state_e state,
    output logic     seg_clr_n,
    output logic     man_blank
);
    wd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (cmd == CMD_BLANK) begin
                    state_d = ST_HELD;            // T_BLANK
                end else if (expired && !evt) begin
                    state_d = ST_STALE;           // T_EXPIRE
                end
            end
            ST_STALE: begin
                if (cmd == CMD_BLANK) begin
                    state_d = ST_HELD;            // T_BLANK
                end else if (evt) begin
                    state_d = ST_RUN;             // T_RESUME
                end
            end
            ST_HELD: begin
                if (cmd == CMD_RESTORE) begin
                    if (evt || !expired) begin
                        state_d = ST_RUN;         // T_RELEASE_LIVE
                    end else begin
                        state_d = ST_STALE;       // T_RELEASE_STALE
                    end
                end
            end
            default: state_d = ST_STALE;
        endcase
    end

    always_comb begin
        seg_clr_n = 1'b0;
        man_blank = 1'b0;
        unique case (state_q)
            ST_RUN:   seg_clr_n = 1'b1;
            ST_STALE: seg_clr_n = 1'b0;
            ST_HELD:  man_blank = 1'b1;
            default:  seg_clr_n = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/disp_blank_wd.sv
module disp_blank_wd
    import disp_blank_wd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic field_stb,
    input  logic seg_stb,
    input  logic blank_cmd,
    input  logic restore_cmd,
    output logic seg_clr_n,
    output logic man_blank
);
    logic      evt;
    logic      expired;
    man_cmd_e  cmd;
    wd_state_e state;

    assign evt = field_stb | seg_stb;

    blk_act_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (evt),
        .expired (expired)
    );

    blk_cmd_arb u_arb (
        .blank_cmd   (blank_cmd),
        .restore_cmd (restore_cmd),
        .cmd         (cmd)
    );

    blk_wd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .expired   (expired),
        .cmd       (cmd),
        .state     (state),
        .seg_clr_n (seg_clr_n),
        .man_blank (man_blank)
    );
endmodule

// File: rtl/disp_blank_wd_chk.sv
module disp_blank_wd_chk #(
    parameter int TIMEOUT_CYC = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic field_stb,
    input logic seg_stb,
    input logic blank_cmd,
    input logic restore_cmd,
    input logic seg_clr_n,
    input logic man_blank
);
    localparam int IW = $clog2(TIMEOUT_CYC + 2) + 1;
    localparam logic [IW-1:0] IMAX = IW'(TIMEOUT_CYC + 1);

    logic [IW-1:0] idle_q;
    logic          evt;
    assign evt = field_stb | seg_stb;

    // Independent count of idle edges since the last event or reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (evt) begin
            idle_q <= '0;
        end else if (idle_q < IMAX) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    assert_idle_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q > IW'(TIMEOUT_CYC)) |-> !seg_clr_n);

    assert_live_not_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q <= IW'(TIMEOUT_CYC) && !man_blank) |-> seg_clr_n);

    assert_resume_on_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!seg_clr_n && !man_blank && evt && !blank_cmd) |=> seg_clr_n);

    assert_hold_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        man_blank |-> !seg_clr_n);

    assert_blank_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_cmd && !restore_cmd) |=> man_blank);

    assert_restore_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restore_cmd |=> !man_blank);

    assert_hold_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (man_blank && !restore_cmd) |=> man_blank);

    assert_both_restore_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_cmd && restore_cmd) |=> !man_blank);
endmodule

bind disp_blank_wd disp_blank_wd_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_stb   (field_stb),
    .seg_stb     (seg_stb),
    .blank_cmd   (blank_cmd),
    .restore_cmd (restore_cmd),
    .seg_clr_n   (seg_clr_n),
    .man_blank   (man_blank)
);

// File: tb/disp_blank_wd_tb_top.sv
`timescale 1ns/1ps
module disp_blank_wd_tb_top;
    localparam int T = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic field_stb = 1'b0;
    logic seg_stb = 1'b0;
    logic blank_cmd = 1'b0;
    logic restore_cmd = 1'b0;
    logic seg_clr_n;
    logic man_blank;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    disp_blank_wd #(.TIMEOUT_CYC(T)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .field_stb   (field_stb),
        .seg_stb     (seg_stb),
        .blank_cmd   (blank_cmd),
        .restore_cmd (restore_cmd),
        .seg_clr_n   (seg_clr_n),
        .man_blank   (man_blank)
    );

    task automatic chk(input string req, input logic act_clr, input logic exp_clr,
                       input logic act_man, input logic exp_man);
        checks++;
        if (act_clr !== exp_clr || act_man !== exp_man) begin
            failures++;
            $display("FAIL %s: seg_clr_n=%b man_blank=%b expected seg_clr_n=%b man_blank=%b",
                     req, act_clr, act_man, exp_clr, exp_man);
        end
    endtask

    // Called at a negedge: apply inputs, pass one rising edge, return at next negedge.
    task automatic step(input logic f, input logic s, input logic b, input logic r);
        field_stb = f; seg_stb = s; blank_cmd = b; restore_cmd = r;
        @(posedge clk);
        @(negedge clk);
        field_stb = 0; seg_stb = 0; blank_cmd = 0; restore_cmd = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset", seg_clr_n, 1'b1, man_blank, 1'b0);
        rst_n = 1'b1;
        step(0, 0, 0, 0);
        chk("R1 after release", seg_clr_n, 1'b1, man_blank, 1'b0);
    endtask

    task automatic t_timeout;
        step(1, 0, 0, 0);
        idle(T);
        chk("R2 last allowed idle edge", seg_clr_n, 1'b1, man_blank, 1'b0);
        step(0, 0, 0, 0);
        chk("R2/R3 timeout clears (active low)", seg_clr_n, 1'b0, man_blank, 1'b0);
        idle(3);
        chk("R3 clear held while idle", seg_clr_n, 1'b0, man_blank, 1'b0);
    endtask

    task automatic t_resume;
        step(0, 1, 0, 0);
        chk("R5 first event releases clear", seg_clr_n, 1'b1, man_blank, 1'b0);
    endtask

    task automatic t_retrigger;
        bit ok = 1'b1;
        for (int k = 0; k < 6; k++) begin
            idle(T);
            if (seg_clr_n !== 1'b1) ok = 1'b0;
            // Event lands on the edge where the counter sits at zero.
            if (k % 2 == 0) step(1, 0, 0, 0); else step(0, 1, 0, 0);
            if (seg_clr_n !== 1'b1) ok = 1'b0;
        end
        chk("R4 alternating strobes keep display live", ok ? 1'b1 : 1'b0, 1'b1, man_blank, 1'b0);
    endtask

    task automatic t_manual;
        step(1, 0, 0, 0);
        step(0, 0, 1, 0);
        chk("R6 blank takes effect", seg_clr_n, 1'b0, man_blank, 1'b1);
        step(1, 0, 0, 0);
        step(0, 1, 0, 0);
        step(1, 1, 0, 0);
        chk("R6 events ignored while held", seg_clr_n, 1'b0, man_blank, 1'b1);
        step(0, 0, 0, 1);
        chk("R7 restore with recent activity", seg_clr_n, 1'b1, man_blank, 1'b0);
    endtask

    task automatic t_both;
        step(1, 0, 0, 0);
        step(0, 0, 1, 1);
        chk("R8 both while running", seg_clr_n, 1'b1, man_blank, 1'b0);
        step(0, 0, 1, 0);
        chk("R6 blank before combined cmd", seg_clr_n, 1'b0, man_blank, 1'b1);
        step(0, 0, 1, 1);
        chk("R8 both while held releases", seg_clr_n, 1'b1, man_blank, 1'b0);
    endtask

    task automatic t_restore_stale;
        step(1, 0, 0, 0);
        step(0, 0, 1, 0);
        idle(T + 3);
        chk("R6 hold survives idle", seg_clr_n, 1'b0, man_blank, 1'b1);
        step(0, 0, 0, 1);
        chk("R9 restore after timeout stays cleared", seg_clr_n, 1'b0, man_blank, 1'b0);
        step(0, 1, 0, 0);
        chk("R5 event after stale restore", seg_clr_n, 1'b1, man_blank, 1'b0);
        idle(T + 1);
        chk("R2 expire again", seg_clr_n, 1'b0, man_blank, 1'b0);
        step(0, 0, 1, 0);
        chk("R6 blank from stale", seg_clr_n, 1'b0, man_blank, 1'b1);
        step(0, 1, 0, 1);
        chk("R7 restore with event in same cycle", seg_clr_n, 1'b1, man_blank, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_timeout();
        t_resume();
        t_retrigger();
        t_manual();
        t_both();
        t_restore_stale();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule